// File: doc/BRIEF.md
# Dual-Slot Receive Frame Assembler

This block takes received Ethernet payload bytes, delivered as a stream with start and end markers, and rebuilds the complete wire-format frame in one of two receive buffers. The rebuilt frame has a regenerated preamble and start delimiter, the payload, zero padding up to the minimum payload size, and a freshly computed CRC-32 frame check sequence. The buffer memory itself sits outside the block and is reached through a byte write port that carries a slot select and a byte address.

Software owns the two slots through a small register write port. Writing the loaded code to a slot's state hands that slot to hardware. When a frame finishes, the block stores the frame length in the slot's count register, moves the slot to pending, and raises a level interrupt that stays high while either slot is pending. Software drains the slot and then writes its state back to empty or loaded. This ping-pong scheme lets one frame be read while the next one lands.

Payload bytes are written to their final offset as they arrive, so the stream is never stalled. The padding, check sequence and preamble are then written in that order after the end marker. The slot is committed in the cycle that writes the last delimiter byte.

Top module: `rx_frame_assembler`

## Requirements
- R1: After reset both slot states are empty (code 0), both counts are zero, `rx_irq` and `ready` are low, and no buffer write occurs.
- R2: A frame that starts while slot 0 holds the loaded code (1) goes to slot 0. Otherwise, if slot 1 holds the loaded code, it goes to slot 1. If neither slot is loaded, the whole frame is dropped with no buffer write and no state change.
- R3: Buffer addresses 0 to 6 of the chosen slot receive 0x55 and address 7 receives 0xD5.
- R4: Payload byte i is written to address 8+i. A payload shorter than 60 bytes is followed by zero bytes up to payload offset 59.
- R5: The 4 bytes that follow the padded payload hold the CRC-32 of the padded payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion.
- R6: On completion the slot count becomes the padded payload length plus 12, and the slot state becomes pending (code 2).
- R7: When payload length plus 12 exceeds BUF_BYTES, the frame is discarded. The slot's state and count keep their values, and no buffer address at or above BUF_BYTES is written.
- R8: `rx_irq` is high exactly when at least one slot state is pending, whether hardware or software wrote that code. It follows a state change in the cycle after the write.
- R9: `ready` is high when at least one slot is loaded and no frame is being received or finished.
- R10: While no frame is in progress, bytes without the start marker are ignored.
- R11: Software writes use `sw_sel` with 0 for slot 0 state, 1 for slot 0 count, 2 for slot 1 state and 3 for slot 1 count. A write is visible on the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte present |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Payload byte |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Software register select |
| sw_wdata | input | CNT_W | Software write data (state uses bits 1:0) |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_slot | output | 1 | Buffer slot of the write |
| wr_addr | output | ADDR_W | Byte address within the slot |
| wr_data | output | 8 | Byte written |
| slot0_state | output | 2 | Slot 0 state code |
| slot0_count | output | CNT_W | Slot 0 frame length |
| slot1_state | output | 2 | Slot 1 state code |
| slot1_count | output | CNT_W | Slot 1 frame length |
| rx_irq | output | 1 | Receive interrupt level |
| ready | output | 1 | A loaded slot is waiting and the assembler is idle |

## Verification
The bench runs with 128-byte buffers and sweeps every payload length from 1 up to the largest one that fits, alternating between the slots and inserting idle gaps into some streams. Each frame is checked byte by byte against a CRC and padding model written independently in the bench. At the 59/60/61 padding boundary, an off-by-one would leave a stale byte or shift the check sequence, which the sentinel-filled model memory exposes. Frames one byte too long, and far too long, must leave the slot untouched; a design that commits them would show a pending state or a changed count. The bench also covers slot priority with both slots loaded, frames dropped with no slot loaded, stray unmarked bytes, and `ready` dropping while a one-byte frame is padded out.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_state_e;

  typedef enum logic [2:0] {
    A_IDLE,
    A_DATA,
    A_SKIP,
    A_PAD,
    A_FCS,
    A_PRE
  } asm_state_e;

  localparam int PRE_LEN     = 8;
  localparam int FCS_LEN     = 4;
  localparam int MIN_PAYLOAD = 60;
  localparam int OVERHEAD    = PRE_LEN + FCS_LEN;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      if (r[0]) r = (r >> 1) ^ CRC_POLY_REFL;
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] lead_byte(input logic [2:0] idx);
    return (idx == 3'd7) ? SFD_BYTE : PRE_BYTE;
  endfunction

  function automatic logic [7:0] fcs_lane(input logic [31:0] crc, input logic [1:0] lane);
    logic [31:0] f;
    f = ~crc;
    return f[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/rxa_crc.sv
module rxa_crc
  import rxa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= '1;
    else if (en) crc_q <= crc32_byte(restart ? 32'hFFFF_FFFF : crc_q, data);
  end

endmodule

// File: rtl/rxa_slot_regs.sv
module rxa_slot_regs
  import rxa_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [1:0]       sw_sel,
  input  logic [CNT_W-1:0] sw_wdata,
  input  logic             commit,
  input  logic             commit_slot,
  input  logic [CNT_W-1:0] commit_count,
  output logic [1:0]       state_q [2],
  output logic [CNT_W-1:0] count_q [2]
);

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic hw_hit, sw_hit;
    assign hw_hit = commit && (commit_slot == 1'(g));
    assign sw_hit = sw_we && (sw_sel[1] == 1'(g));

    // A hardware commit wins over a software write in the same cycle.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_q[g] <= SLOT_EMPTY;
        count_q[g] <= '0;
      end else if (hw_hit) begin
        state_q[g] <= SLOT_PENDING;
        count_q[g] <= commit_count;
      end else if (sw_hit) begin
        if (sw_sel[0]) count_q[g] <= sw_wdata;
        else           state_q[g] <= sw_wdata[1:0];
      end
    end
  end

endmodule

// File: rtl/rxa_assembler.sv
module rxa_assembler
  import rxa_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 11,
  parameter int CNT_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  input  logic [1:0]        slot_loaded,
  input  logic [31:0]       crc_q,
  output logic              crc_en,
  output logic              crc_restart,
  output logic [7:0]        crc_byte,
  output logic              wr_en,
  output logic              wr_slot,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic              commit_slot,
  output logic [CNT_W-1:0]  commit_count,
  output logic              busy
);

  localparam logic [LEN_W-1:0] L_BUF     = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] L_MAXPAY  = LEN_W'(BUF_BYTES - OVERHEAD);
  localparam logic [LEN_W-1:0] L_MIN     = LEN_W'(MIN_PAYLOAD);
  localparam logic [LEN_W-1:0] L_PRE     = LEN_W'(PRE_LEN);

  asm_state_e        st_q, st_d;
  logic [LEN_W-1:0]  len_q, len_d, len_inc, pay_addr;
  logic              slot_q, slot_d;
  logic              ovf_q, ovf_d;
  logic [2:0]        idx_q, idx_d;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        data_d;

  assign len_inc      = (len_q == L_BUF) ? len_q : len_q + 1'b1;
  assign pay_addr     = L_PRE + len_q;
  assign busy         = (st_q != A_IDLE);
  assign commit_slot  = slot_q;
  assign commit_count = CNT_W'(len_q + LEN_W'(OVERHEAD));

  always_comb begin
    st_d        = st_q;
    len_d       = len_q;
    slot_d      = slot_q;
    ovf_d       = ovf_q;
    idx_d       = idx_q;
    we_d        = 1'b0;
    addr_d      = ADDR_W'(pay_addr);
    data_d      = in_data;
    crc_en      = 1'b0;
    crc_restart = 1'b0;
    crc_byte    = in_data;
    commit      = 1'b0;
    unique case (st_q)
      A_IDLE: begin
        if (in_valid && in_first) begin
          if (|slot_loaded) begin
            slot_d      = slot_loaded[0] ? 1'b0 : 1'b1;
            we_d        = 1'b1;
            addr_d      = ADDR_W'(PRE_LEN);
            crc_en      = 1'b1;
            crc_restart = 1'b1;
            len_d       = LEN_W'(1);
            ovf_d       = 1'b0;
            idx_d       = '0;
            st_d        = in_last ? A_PAD : A_DATA;
          end else if (!in_last) begin
            st_d = A_SKIP;
          end
        end
      end
      A_DATA: begin
        if (in_valid) begin
          we_d   = (pay_addr < L_BUF);
          crc_en = 1'b1;
          len_d  = len_inc;
          ovf_d  = ovf_q | (len_inc > L_MAXPAY);
          idx_d  = '0;
          if (in_last) begin
            if (ovf_d)                st_d = A_IDLE;
            else if (len_inc < L_MIN) st_d = A_PAD;
            else                      st_d = A_FCS;
          end
        end
      end
      A_SKIP: begin
        if (in_valid && in_last) st_d = A_IDLE;
      end
      A_PAD: begin
        we_d     = 1'b1;
        data_d   = 8'h00;
        crc_byte = 8'h00;
        crc_en   = 1'b1;
        len_d    = len_q + 1'b1;
        if (len_d == L_MIN) begin
          st_d  = A_FCS;
          idx_d = '0;
        end
      end
      A_FCS: begin
        we_d   = 1'b1;
        addr_d = ADDR_W'(pay_addr + LEN_W'(idx_q));
        data_d = fcs_lane(crc_q, idx_q[1:0]);
        idx_d  = idx_q + 1'b1;
        if (idx_q == 3'd3) begin
          st_d  = A_PRE;
          idx_d = '0;
        end
      end
      A_PRE: begin
        we_d   = 1'b1;
        addr_d = ADDR_W'(idx_q);
        data_d = lead_byte(idx_q);
        idx_d  = idx_q + 1'b1;
        if (idx_q == 3'd7) begin
          commit = 1'b1;
          st_d   = A_IDLE;
        end
      end
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= A_IDLE;
      len_q   <= '0;
      slot_q  <= 1'b0;
      ovf_q   <= 1'b0;
      idx_q   <= '0;
      wr_en   <= 1'b0;
      wr_slot <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      st_q    <= st_d;
      len_q   <= len_d;
      slot_q  <= slot_d;
      ovf_q   <= ovf_d;
      idx_q   <= idx_d;
      wr_en   <= we_d;
      wr_slot <= slot_d;
      wr_addr <= addr_d;
      wr_data <= data_d;
    end
  end

endmodule

// File: rtl/rx_frame_assembler.sv
module rx_frame_assembler
  import rxa_pkg::*;
#(
  parameter  int BUF_BYTES = 2048,
  localparam int CNT_W     = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [CNT_W-1:0]  sw_wdata,
  output logic              wr_en,
  output logic              wr_slot,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [1:0]        slot0_state,
  output logic [CNT_W-1:0]  slot0_count,
  output logic [1:0]        slot1_state,
  output logic [CNT_W-1:0]  slot1_count,
  output logic              rx_irq,
  output logic              ready
);

  localparam int LEN_W = $clog2(BUF_BYTES + PRE_LEN + 1);

  logic [1:0]       state_q [2];
  logic [CNT_W-1:0] count_q [2];
  logic [1:0]       slot_loaded;
  logic             commit_fire, commit_slot, busy;
  logic [CNT_W-1:0] commit_count;
  logic             crc_en, crc_restart;
  logic [7:0]       crc_byte;
  logic [31:0]      crc_q;

  assign slot_loaded = {state_q[1] == SLOT_LOADED, state_q[0] == SLOT_LOADED};
  assign slot0_state = state_q[0];
  assign slot1_state = state_q[1];
  assign slot0_count = count_q[0];
  assign slot1_count = count_q[1];
  assign rx_irq      = (state_q[0] == SLOT_PENDING) || (state_q[1] == SLOT_PENDING);
  assign ready       = (|slot_loaded) && !busy;

  rxa_assembler #(
    .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_asm (
    .clk, .rst_n, .in_valid, .in_first, .in_last, .in_data,
    .slot_loaded, .crc_q, .crc_en, .crc_restart, .crc_byte,
    .wr_en, .wr_slot, .wr_addr, .wr_data,
    .commit(commit_fire), .commit_slot, .commit_count, .busy
  );

  rxa_crc u_crc (
    .clk, .rst_n, .en(crc_en), .restart(crc_restart), .data(crc_byte), .crc_q
  );

  rxa_slot_regs #(.CNT_W(CNT_W)) u_slots (
    .clk, .rst_n, .sw_we, .sw_sel, .sw_wdata,
    .commit(commit_fire), .commit_slot, .commit_count,
    .state_q, .count_q
  );

endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
  parameter  int BUF_BYTES = 2048,
  localparam int CNT_W     = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              commit_fire,
  input logic              commit_slot,
  input logic [CNT_W-1:0]  commit_count,
  input logic [1:0]        slot0_state,
  input logic [1:0]        slot1_state,
  input logic              rx_irq,
  input logic              ready
);

  p_preamble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(7)) |-> (wr_data == 8'h55));

  p_sfd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(7)) |-> (wr_data == 8'hD5));

  p_min_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (commit_count >= CNT_W'(72)));

  p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (($past(commit_slot) ? slot1_state : slot0_state) == 2'd2));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (commit_count <= CNT_W'(BUF_BYTES)));

  p_irq_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> rx_irq);

  p_ready_needs_loaded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (slot0_state == 2'd1 || slot1_state == 2'd1));

endmodule

bind rx_frame_assembler rxa_checker #(.BUF_BYTES(BUF_BYTES)) u_rxa_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .commit_fire(commit_fire), .commit_slot(commit_slot), .commit_count(commit_count),
  .slot0_state(slot0_state), .slot1_state(slot1_state), .rx_irq(rx_irq), .ready(ready)
);

// File: tb/test_rx_frame_assembler.sv
module test_rx_frame_assembler;

  localparam int BUF    = 128;
  localparam int CW     = $clog2(BUF + 1);
  localparam int AW     = $clog2(BUF);
  localparam int MAXPAY = BUF - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0]    in_data = 0;
  logic          sw_we = 0;
  logic [1:0]    sw_sel = 0;
  logic [CW-1:0] sw_wdata = 0;
  logic          wr_en, wr_slot;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [1:0]    slot0_state, slot1_state;
  logic [CW-1:0] slot0_count, slot1_count;
  logic          rx_irq, ready;

  rx_frame_assembler #(.BUF_BYTES(BUF)) i_rx_frame_assembler (
    .clk, .rst_n, .in_valid, .in_first, .in_last, .in_data,
    .sw_we, .sw_sel, .sw_wdata, .wr_en, .wr_slot, .wr_addr, .wr_data,
    .slot0_state, .slot0_count, .slot1_state, .slot1_count, .rx_irq, .ready
  );

  logic [7:0] mem [2][BUF];
  int wr_count = 0;
  int checks = 0;
  int errors = 0;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_slot][wr_addr] = wr_data;
      wr_count++;
    end
  end

  initial begin
    #(150000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + (i >> 3)) ^ 8'h5C);
  endfunction

  // Independent CRC model, mask form.
  function automatic logic [31:0] model_fcs(input int len, input int seed);
    logic [31:0] c = 32'hFFFF_FFFF;
    int plen = (len < 60) ? 60 : len;
    for (int i = 0; i < plen; i++) begin
      c = c ^ {24'd0, (i < len) ? pbyte(seed, i) : 8'h00};
      for (int k = 0; k < 8; k++) c = (c >> 1) ^ (32'hEDB88320 & {32{c[0]}});
    end
    return ~c;
  endfunction

  function automatic logic [1:0] st_of(input int s);
    return s ? slot1_state : slot0_state;
  endfunction

  function automatic int cnt_of(input int s);
    return s ? int'(slot1_count) : int'(slot0_count);
  endfunction

  task automatic sw_wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    sw_we = 1; sw_sel = sel; sw_wdata = CW'(val);
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic send(input int len, input int seed, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk);
        in_valid = 0;
      end
      @(negedge clk);
      in_valid = 1; in_first = (i == 0); in_last = (i == len - 1);
      in_data = pbyte(seed, i);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic wait_done(input int s);
    for (int t = 0; t < 200; t++) begin
      if (st_of(s) != 2'd1) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_frame(input int s, input int len, input int seed);
    int plen = (len < 60) ? 60 : len;
    logic [31:0] f = model_fcs(len, seed);
    int bad_pre = -1, bad_pay = -1, bad_fcs = -1;
    for (int a = 0; a < 8; a++)
      if (bad_pre < 0 && mem[s][a] != ((a == 7) ? 8'hD5 : 8'h55)) bad_pre = a;
    for (int i = 0; i < plen; i++)
      if (bad_pay < 0 && mem[s][8 + i] != ((i < len) ? pbyte(seed, i) : 8'h00)) bad_pay = i;
    for (int k = 0; k < 4; k++)
      if (bad_fcs < 0 && mem[s][8 + plen + k] != f[8 * k +: 8]) bad_fcs = k;
    chk(st_of(s) == 2'd2, $sformatf("R6 slot%0d state len %0d", s, len), st_of(s), 2);
    chk(cnt_of(s) == plen + 12, $sformatf("R6 slot%0d count len %0d", s, len), cnt_of(s), plen + 12);
    chk(bad_pre < 0, $sformatf("R3 lead byte index, len %0d", len), bad_pre, -1);
    chk(bad_pay < 0, $sformatf("R4 payload/pad index, len %0d", len), bad_pay, -1);
    chk(bad_fcs < 0, $sformatf("R5 fcs lane, len %0d", len), bad_fcs, -1);
    chk(rx_irq == 1'b1, "R8 irq after commit", rx_irq, 1);
  endtask

  task automatic run_frame(input int s, input int len, input int seed, input bit gaps);
    for (int a = 0; a < BUF; a++) mem[s][a] = 8'hAA;
    send(len, seed, gaps);
    wait_done(s);
    check_frame(s, len, seed);
  endtask

  initial begin
    int wrc;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(slot0_state == 0 && slot1_state == 0, "R1 states", {slot1_state, slot0_state}, 0);
    chk(slot0_count == 0 && slot1_count == 0, "R1 counts", int'(slot0_count) + int'(slot1_count), 0);
    chk(!rx_irq && !ready, "R1 irq/ready", {rx_irq, ready}, 0);
    chk(wr_count == 0, "R1 no writes", wr_count, 0);

    // R5 bench CRC model sanity on the standard check string
    begin
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 9; i++) begin
        c = c ^ {24'd0, 8'(8'h31 + i)};
        for (int k = 0; k < 8; k++) c = (c >> 1) ^ (32'hEDB88320 & {32{c[0]}});
      end
      chk(~c == 32'hCBF43926, "R5 model vector", ~c, 32'hCBF43926);
    end

    // R11 software write readback, R9 ready once loaded, R10 stray bytes
    sw_wr(2'd3, 8'h33);
    chk(slot1_count == CW'(8'h33), "R11 count1 write", slot1_count, 8'h33);
    sw_wr(2'd0, 1);
    chk(slot0_state == 2'd1, "R11 state0 write", slot0_state, 1);
    chk(ready == 1'b1, "R9 ready with loaded slot", ready, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1; in_first = 0; in_last = (i == 4); in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    repeat (3) @(negedge clk);
    chk(wr_count == 0, "R10 unmarked bytes ignored", wr_count, 0);
    chk(slot0_state == 2'd1, "R10 slot untouched", slot0_state, 1);

    // R9 ready low while a one-byte frame is being finished
    for (int a = 0; a < BUF; a++) mem[0][a] = 8'hAA;
    @(negedge clk);
    in_valid = 1; in_first = 1; in_last = 1; in_data = pbyte(9, 0);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    chk(ready == 1'b0, "R9 ready low while busy", ready, 0);
    wait_done(0);
    check_frame(0, 1, 9);
    sw_wr(2'd0, 0);
    chk(rx_irq == 1'b0, "R8 irq cleared", rx_irq, 0);

    // R2 R3 R4 R5 R6 sweep over every fitting length, alternating slots
    for (int len = 1; len <= MAXPAY; len++) begin
      int s = len % 2;
      sw_wr(s ? 2'd2 : 2'd0, 1);
      run_frame(s, len, len + 3, (len % 3) == 0);
      sw_wr(s ? 2'd2 : 2'd0, 0);
      chk(rx_irq == 1'b0, $sformatf("R8 irq low after clear, len %0d", len), rx_irq, 0);
    end

    // R2 priority with both loaded
    sw_wr(2'd0, 1);
    sw_wr(2'd2, 1);
    run_frame(0, 70, 5, 1'b0);
    chk(slot1_state == 2'd1, "R2 slot1 kept when slot0 loaded", slot1_state, 1);
    run_frame(1, 64, 6, 1'b1);
    chk(ready == 1'b0, "R9 ready low with no loaded slot", ready, 0);
    sw_wr(2'd0, 0);
    chk(rx_irq == 1'b1, "R8 irq held by slot1 pending", rx_irq, 1);
    sw_wr(2'd2, 0);

    // R2 drop when nothing loaded
    wrc = wr_count;
    send(30, 7, 1'b0);
    repeat (10) @(negedge clk);
    chk(wr_count == wrc, "R2 dropped frame writes", wr_count - wrc, 0);
    chk(slot0_state == 0 && slot1_state == 0, "R2 dropped frame states", {slot1_state, slot0_state}, 0);

    // R7 oversize frames leave the slot untouched
    sw_wr(2'd0, 1);
    sw_wr(2'd1, 8'h5A);
    send(MAXPAY + 1, 8, 1'b0);
    repeat (20) @(negedge clk);
    chk(slot0_state == 2'd1, "R7 state after oversize", slot0_state, 1);
    chk(slot0_count == CW'(8'h5A), "R7 count after oversize", slot0_count, 8'h5A);
    chk(rx_irq == 1'b0, "R7 no irq after oversize", rx_irq, 0);
    send(150, 9, 1'b1);
    repeat (20) @(negedge clk);
    chk(slot0_state == 2'd1 && slot0_count == CW'(8'h5A), "R7 far oversize", slot0_count, 8'h5A);
    run_frame(0, MAXPAY, 10, 1'b0);
    sw_wr(2'd0, 0);

    // R8 software-written pending code
    sw_wr(2'd2, 2);
    chk(rx_irq == 1'b1, "R8 irq from software pending", rx_irq, 1);
    sw_wr(2'd2, 0);
    chk(rx_irq == 1'b0, "R8 irq drops", rx_irq, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule